// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block records translation faults for software. A translation unit pulses `fault_valid` together with a fault code, the table level at which the walk stopped, a three-bit access index and the faulting virtual address. The recorder builds a status word from these fields and stores it. It loads the address into a separate address register. Software reads the status word through a read strobe, and the read empties the register.

A second fault can arrive before software has read the first one. In that case the old contents are replaced by a single overflow bit, and the new fields are merged on top. The block also decides whether the fault becomes a trap. It gives an instruction-access trap for instruction fetches and a data-access trap for any other access. No trap is raised while no-fault mode is on or while traps are disabled. Vectoring of the trap is done elsewhere.

Top module: `fault_status_rec`

## Requirements
- R1: After reset the status word and the fault address are zero, and both trap outputs are low.
- R2: A fault into an empty status register leaves this status word on `status_rdata` from the next cycle: bit 1 = 1 (address valid), bits 4:2 = fault code, bits 7:5 = access index, bits 9:8 = level, and all other bits 0.
- R3: A fault that arrives while the status word is nonzero stores 1 (bit 0, overflow) ORed with the fields of R2 for the new fault. The fields of the earlier fault are discarded.
- R4: On every fault, with or without overflow, `fault_addr` takes the faulting virtual address from the next cycle.
- R5: `status_rdata` always shows the stored status. A cycle with `status_rd` high and no fault clears the status word to zero from the next cycle.
- R6: When a fault and a read occur in the same cycle, the fault wins. The stored value is the fault value computed from the status before the read, so overflow is set if that status was nonzero.
- R7: With `nofault_mode` low and `traps_en` high, a fault raises a one-cycle pulse in the next cycle. The pulse is on `trap_instr` when access index bit 1 (instruction fetch) is 1, and on `trap_data` otherwise.
- R8: With `nofault_mode` high or `traps_en` low, a fault raises no trap. The status word and the address are still recorded.
- R9: In a cycle with neither a fault nor a read, the status word and the fault address keep their values and no trap pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | One-cycle fault pulse from the translation unit |
| fault_code | input | 3 | Fault type code |
| fault_level | input | 2 | Table level at which the walk stopped |
| fault_acc | input | 3 | Access index; bit 1 marks an instruction fetch |
| fault_vaddr | input | AW (32) | Faulting virtual address |
| nofault_mode | input | 1 | No-fault mode; suppresses traps |
| traps_en | input | 1 | Trap enable; traps are suppressed when low |
| status_rd | input | 1 | Status read strobe; clears the status word |
| status_rdata | output | SW (32) | Current status word |
| fault_addr | output | AW (32) | Fault address register |
| trap_instr | output | 1 | Instruction-access trap pulse |
| trap_data | output | 1 | Data-access trap pulse |

## Verification
On every cycle the assertions check several rules: the address-valid bit after each fault, the overflow bit whenever the previous status was nonzero, the address capture, clearing on a read, holding while idle, and that at most one trap pulses, with none while suppressed. Some results can only be shown by the bench scenarios, which compare each cycle against an independent model. These are the exact placement of the code, level and access fields, the discarding of the old fields on overflow, the fault-over-read outcome, and the choice between the instruction trap and the data trap.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int OVF_BIT    = 0;
    localparam int AVLD_BIT   = 1;
    localparam int CODE_LSB   = 2;
    localparam int CODE_W     = 3;
    localparam int ACC_LSB    = 5;
    localparam int ACC_W      = 3;
    localparam int LVL_LSB    = 8;
    localparam int LVL_W      = 2;
    localparam int IFETCH_BIT = 1;
    localparam int MIN_SW     = LVL_LSB + LVL_W;
endpackage

// File: rtl/fsr_status_next.sv
module fsr_status_next
    import fsr_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic [SW-1:0]     cur_sts,
    input  logic [CODE_W-1:0] code,
    input  logic [ACC_W-1:0]  acc,
    input  logic [LVL_W-1:0]  lvl,
    output logic [SW-1:0]     new_sts
);
    always_comb begin
        new_sts = '0;
        new_sts[OVF_BIT]              = |cur_sts;
        new_sts[AVLD_BIT]             = 1'b1;
        new_sts[CODE_LSB +: CODE_W]   = code;
        new_sts[ACC_LSB +: ACC_W]     = acc;
        new_sts[LVL_LSB +: LVL_W]     = lvl;
    end
endmodule

// File: rtl/fsr_trap_pick.sv
module fsr_trap_pick
    import fsr_pkg::*;
(
    input  logic             valid,
    input  logic [ACC_W-1:0] acc,
    input  logic             nofault_mode,
    input  logic             traps_en,
    output logic             want_instr,
    output logic             want_data
);
    logic allow;
    always_comb begin
        allow      = valid && !nofault_mode && traps_en;
        want_instr = allow && acc[IFETCH_BIT];
        want_data  = allow && !acc[IFETCH_BIT];
    end
endmodule

// File: rtl/fault_status_rec.sv
module fault_status_rec
    import fsr_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fault_valid,
    input  logic [CODE_W-1:0]    fault_code,
    input  logic [LVL_W-1:0]     fault_level,
    input  logic [ACC_W-1:0]     fault_acc,
    input  logic [AW-1:0]        fault_vaddr,
    input  logic                 nofault_mode,
    input  logic                 traps_en,
    input  logic                 status_rd,
    output logic [SW-1:0]        status_rdata,
    output logic [AW-1:0]        fault_addr,
    output logic                 trap_instr,
    output logic                 trap_data
);
    typedef struct packed {
        logic [SW-1:0] sts;
        logic [AW-1:0] far;
        logic          t_i;
        logic          t_d;
    } rec_t;

    rec_t          st_d, st_q;
    logic [SW-1:0] fault_sts;
    logic          pick_i, pick_d;

    initial begin
        if (SW < MIN_SW) $error("SW too narrow for status fields");
    end

    fsr_status_next #(.SW(SW)) u_next (
        .cur_sts (st_q.sts),
        .code    (fault_code),
        .acc     (fault_acc),
        .lvl     (fault_level),
        .new_sts (fault_sts)
    );

    fsr_trap_pick u_pick (
        .valid        (fault_valid),
        .acc          (fault_acc),
        .nofault_mode (nofault_mode),
        .traps_en     (traps_en),
        .want_instr   (pick_i),
        .want_data    (pick_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.t_i = 1'b0;
        st_d.t_d = 1'b0;
        if (fault_valid) begin
            st_d.sts = fault_sts;
            st_d.far = fault_vaddr;
            st_d.t_i = pick_i;
            st_d.t_d = pick_d;
        end else if (status_rd) begin
            st_d.sts = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_rdata = st_q.sts;
    assign fault_addr   = st_q.far;
    assign trap_instr   = st_q.t_i;
    assign trap_data    = st_q.t_d;

    // R2
    addr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> status_rdata[AVLD_BIT]);
    // R3
    overflow_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && (status_rdata != '0)) |=> status_rdata[OVF_BIT]);
    // R4
    far_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (fault_addr == $past(fault_vaddr)));
    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !fault_valid) |=> (status_rdata == '0));
    // R7
    one_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_instr, trap_data}));
    // R8
    suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && (nofault_mode || !traps_en)) |=> !(trap_instr || trap_data));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_valid && !status_rd) |=> ($stable(status_rdata) && $stable(fault_addr)
                                          && !trap_instr && !trap_data));
endmodule

// File: tb/sim_fault_status_rec.sv
module sim_fault_status_rec;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fault_valid = 1'b0;
    logic [2:0]    fault_code = '0;
    logic [1:0]    fault_level = '0;
    logic [2:0]    fault_acc = '0;
    logic [AW-1:0] fault_vaddr = '0;
    logic          nofault_mode = 1'b0;
    logic          traps_en = 1'b1;
    logic          status_rd = 1'b0;
    logic [SW-1:0] status_rdata;
    logic [AW-1:0] fault_addr;
    logic          trap_instr, trap_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    longint m_sts = 0;
    longint m_far = 0;
    bit     m_ti = 0, m_td = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_status_rec #(.AW(AW), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_code(fault_code),
        .fault_level(fault_level), .fault_acc(fault_acc), .fault_vaddr(fault_vaddr),
        .nofault_mode(nofault_mode), .traps_en(traps_en), .status_rd(status_rd),
        .status_rdata(status_rdata), .fault_addr(fault_addr),
        .trap_instr(trap_instr), .trap_data(trap_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint fields(int code, int acc, int lvl);
        return longint'((acc << 5) | (code << 2) | (lvl << 8) | 2);
    endfunction

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sts <= 0; m_far <= 0; m_ti <= 0; m_td <= 0;
        end else if (fault_valid) begin
            m_sts <= (m_sts != 0 ? 1 : 0) | fields(fault_code, fault_acc, fault_level);
            m_far <= longint'(fault_vaddr);
            m_ti  <= !nofault_mode && traps_en && fault_acc[1];
            m_td  <= !nofault_mode && traps_en && !fault_acc[1];
        end else begin
            if (status_rd) m_sts <= 0;
            m_ti <= 0; m_td <= 0;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(longint'(status_rdata) == m_sts, "R2 status", longint'(status_rdata), m_sts);
            chk(longint'(fault_addr) == m_far, "R4 far", longint'(fault_addr), m_far);
            chk({trap_instr, trap_data} == {m_ti, m_td}, "R7 trap",
                {trap_instr, trap_data}, {m_ti, m_td});
        end
    end

    task automatic drive(input bit fv, input int code, input int acc, input int lvl,
                         input longint addr, input bit rd);
        @(posedge clk); #1;
        fault_valid = fv; fault_code = 3'(code); fault_acc = 3'(acc);
        fault_level = 2'(lvl); fault_vaddr = AW'(addr); status_rd = rd;
        @(posedge clk); #1;
        fault_valid = 0; status_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(status_rdata == 0 && fault_addr == 0, "R1", status_rdata, 0);
        chk(!trap_instr && !trap_data, "R1 traps", {trap_instr, trap_data}, 0);

        // R2 field layout, instruction fetch trap (R7)
        drive(1, 3, 2, 1, 64'h1234_5000, 0);
        chk(status_rdata == 32'd334, "R2", status_rdata, 334);
        chk(trap_instr && !trap_data, "R7 instr", {trap_instr, trap_data}, 2);

        // R3 overflow discards old fields, data trap
        drive(1, 4, 1, 2, 64'hCAFE_0000, 0);
        chk(status_rdata == 32'(1 | fields(4, 1, 2)), "R3", status_rdata, 1 | fields(4, 1, 2));
        chk(fault_addr == 32'hCAFE_0000, "R4", fault_addr, 64'hCAFE_0000);
        chk(!trap_instr && trap_data, "R7 data", {trap_instr, trap_data}, 1);

        // R5 read clears
        drive(0, 0, 0, 0, 0, 1);
        chk(status_rdata == 0, "R5", status_rdata, 0);

        // R8 no-fault mode and trap-disable
        nofault_mode = 1;
        drive(1, 1, 2, 0, 64'h0000_A000, 0);
        chk(!trap_instr && !trap_data, "R8 nofault", {trap_instr, trap_data}, 0);
        chk(status_rdata == 32'(fields(1, 2, 0)), "R8 recorded", status_rdata, fields(1, 2, 0));
        nofault_mode = 0; traps_en = 0;
        drive(1, 2, 4, 3, 64'h0000_B000, 0);
        chk(!trap_instr && !trap_data, "R8 disabled", {trap_instr, trap_data}, 0);
        chk(fault_addr == 32'h0000_B000, "R8 far", fault_addr, 64'hB000);
        traps_en = 1;

        // R6 fault and read in same cycle: fault wins, overflow from pre-read value
        drive(1, 5, 0, 1, 64'h0000_C000, 1);
        chk(status_rdata == 32'(1 | fields(5, 0, 1)), "R6", status_rdata, 1 | fields(5, 0, 1));

        // R9 idle hold
        @(posedge clk); @(posedge clk); #1;
        chk(status_rdata == 32'(1 | fields(5, 0, 1)) && fault_addr == 32'h0000_C000, "R9",
            status_rdata, 1 | fields(5, 0, 1));

        // mixed pattern phase
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            fault_valid  = ($urandom % 3) == 0;
            status_rd    = ($urandom % 4) == 0;
            fault_code   = 3'($urandom);
            fault_acc    = 3'($urandom);
            fault_level  = 2'($urandom);
            fault_vaddr  = AW'($urandom);
            nofault_mode = ($urandom % 5) == 0;
            traps_en     = ($urandom % 5) != 0;
        end
        @(posedge clk); #1;
        fault_valid = 0; status_rd = 0;
        @(posedge clk); #1;
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule